// File: doc/BRIEF.md
# Dual-Bank Shared Scratch RAM Arbiter

This block lets three masters share one 32 KB scratch RAM that is built from two physically separate 16 KB SRAM banks. A CPU fetch port (read-only) and a CPU load/store port each reach the RAM through their own address window. Both windows alias the same storage, so code written through the load/store port can be fetched later. A third port serves any non-CPU master as DMA traffic and addresses the RAM by its plain byte offset.

Each bank has its own arbiter, so accesses that land in different banks complete in the same cycle. When two masters want the same bank, the CPU ports win over DMA. Between the fetch and load/store ports, each bank keeps a turn bit that flips after every clash between them. A master that loses sees `ready` low and keeps its request unchanged. The grant is the cycle in which `ready` is high, and read data appears on the master's `rdata` in the cycle after that. The bank-side ports drive an external single-cycle SRAM that has byte-write enables.

Top module: `tcm_bank_arbiter`

## Requirements
- R1: The fetch port serves byte addresses 0x0000 to 0x7FFF. It has no write path, and no bank write is ever issued on its behalf.
- R2: The load/store port serves byte addresses 0x10000 to 0x17FFF. Window offset N on the fetch port, the load/store port and the DMA port (whose 15-bit address is the offset itself) all reach the same 32-bit word.
- R3: A fetch or load/store request outside its window is answered with `ready` high in the same cycle. It touches no bank, and its `rdata` in the next cycle is zero.
- R4: Bit 14 of the offset selects the bank (0 or 1), and offset bits 13:2 form the bank word address. Requests to different banks are all granted in the same cycle. A bank with any request pending is never left idle.
- R5: On a bank wanted by the DMA port and by at least one CPU port, a CPU port is granted and the DMA port waits.
- R6: When the fetch and load/store ports clash on one bank, that bank's turn bit decides the winner. The turn bit favours fetch after reset and flips after every such clash. Each bank has its own turn bit.
- R7: `ready` is high exactly in the grant cycle. A losing master sees `ready` low and is served once it wins, while holding its request unchanged.
- R8: For a granted read, `rdata` carries the addressed word in the cycle after the grant. In every other cycle `rdata` is zero.
- R9: A write changes only the bytes whose byte-enable bit is 1 (bit k covers data bits 8k+7:8k). All other bytes of the word keep their value.
- R10: After synchronous reset (active low), `rdata` is zero on every port and both turn bits favour fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_req | input | 1 | Fetch request |
| ins_addr | input | 17 | Fetch byte address |
| ins_ready | output | 1 | Fetch granted or answered this cycle |
| ins_rdata | output | 32 | Fetch data, one cycle after grant |
| dat_req | input | 1 | Load/store request |
| dat_addr | input | 17 | Load/store byte address |
| dat_we | input | 1 | Load/store write |
| dat_be | input | 4 | Load/store byte enables |
| dat_wdata | input | 32 | Load/store write data |
| dat_ready | output | 1 | Load/store granted or answered |
| dat_rdata | output | 32 | Load/store read data |
| dma_req | input | 1 | DMA request |
| dma_addr | input | 15 | DMA byte offset into the RAM |
| dma_we | input | 1 | DMA write |
| dma_be | input | 4 | DMA byte enables |
| dma_wdata | input | 32 | DMA write data |
| dma_ready | output | 1 | DMA granted |
| dma_rdata | output | 32 | DMA read data |
| bk_en | output | 2 | Per-bank access enable |
| bk_we | output | 2 | Per-bank write |
| bk_be | output | 2x4 | Per-bank byte enables |
| bk_addr | output | 2x12 | Per-bank word address |
| bk_wdata | output | 2x32 | Per-bank write data |
| bk_rdata | input | 2x32 | Per-bank read data, one cycle after enable |

## Verification
Assertions check on every cycle that each bank grants at most one master and never idles while a request waits. They also check that DMA never wins a bank a CPU port wants, that a turn bit flips after each fetch/load-store clash, that the fetch port never causes a bank write, and that an out-of-window request starts no bank access. Only the bench scenarios can show aliasing, byte-merge results, the exact winner sequence under alternation and the timing of returned data. For those, the bench's behavioural model predicts `ready` and `rdata` on every port in every cycle, against an SRAM driven from the bank ports.

// File: rtl/tcm_arb_pkg.sv
// Shared types for the dual-bank scratch RAM arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package tcm_arb_pkg;

    // Which master owns a bank in the current cycle.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_INS  = 2'd1,
        OWN_DAT  = 2'd2,
        OWN_DMA  = 2'd3
    } bank_owner_e;

endpackage

// File: rtl/tcm_win_decode.sv
// Window decoder: checks whether a CPU byte address falls inside the
// aligned window that starts at BASE and returns the offset within it.
// Assumes: BASE is aligned to 2**OFF_W.
module tcm_win_decode #(
    parameter int                ADDR_W = 17,
    parameter int                OFF_W  = 15,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [OFF_W-1:0]  offset
);

    // Compare the bits above the window size against the base.
    always_comb begin
        in_win = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
        offset = addr[OFF_W-1:0];
    end

endmodule

// File: rtl/tcm_bank_arb.sv
// Per-bank arbiter: picks one of fetch, load/store and DMA for a bank and
// drives that bank's SRAM port. CPU ports beat DMA. A fetch/load-store
// clash is settled by a turn bit that flips after each clash.
// Assumes: hit_* inputs are already qualified by window and bank select.
module tcm_bank_arb
    import tcm_arb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 12,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_ins,
    input  logic [IDX_W-1:0]  idx_ins,
    input  logic              hit_dat,
    input  logic [IDX_W-1:0]  idx_dat,
    input  logic              we_dat,
    input  logic [BE_W-1:0]   be_dat,
    input  logic [DATA_W-1:0] wdata_dat,
    input  logic              hit_dma,
    input  logic [IDX_W-1:0]  idx_dma,
    input  logic              we_dma,
    input  logic [BE_W-1:0]   be_dma,
    input  logic [DATA_W-1:0] wdata_dma,
    output logic              gnt_ins,
    output logic              gnt_dat,
    output logic              gnt_dma,
    output logic              bk_en,
    output logic              bk_we,
    output logic [BE_W-1:0]   bk_be,
    output logic [IDX_W-1:0]  bk_idx,
    output logic [DATA_W-1:0] bk_wdata
);

    logic        dat_turn_q;   // 1: load/store wins the next clash
    logic        clash;
    bank_owner_e owner;

    assign clash = hit_ins & hit_dat;

    // Choose the bank owner: CPU before DMA, turn bit between CPU ports.
    always_comb begin
        if (clash)        owner = dat_turn_q ? OWN_DAT : OWN_INS;
        else if (hit_ins) owner = OWN_INS;
        else if (hit_dat) owner = OWN_DAT;
        else if (hit_dma) owner = OWN_DMA;
        else              owner = OWN_NONE;
    end

    // Flip the turn bit after every fetch/load-store clash.
    always_ff @(posedge clk) begin
        if (!rst_n)     dat_turn_q <= 1'b0;
        else if (clash) dat_turn_q <= ~dat_turn_q;
    end

    // Decode the owner into per-master grants.
    always_comb begin
        gnt_ins = (owner == OWN_INS);
        gnt_dat = (owner == OWN_DAT);
        gnt_dma = (owner == OWN_DMA);
    end

    // Steer the owner's request onto the bank port.
    always_comb begin
        bk_en    = 1'b1;
        bk_we    = 1'b0;
        bk_be    = '0;
        bk_idx   = '0;
        bk_wdata = '0;
        case (owner)
            OWN_INS: bk_idx = idx_ins;
            OWN_DAT: begin
                bk_idx   = idx_dat;
                bk_we    = we_dat;
                bk_be    = be_dat;
                bk_wdata = wdata_dat;
            end
            OWN_DMA: begin
                bk_idx   = idx_dma;
                bk_we    = we_dma;
                bk_be    = be_dma;
                bk_wdata = wdata_dma;
            end
            default: bk_en = 1'b0;
        endcase
    end

    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_ins, gnt_dat, gnt_dma}));

    p_busy_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ins || hit_dat || hit_dma) |-> bk_en);

    p_cpu_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ins || hit_dat) |-> !gnt_dma);

    p_turn_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> (dat_turn_q != $past(dat_turn_q)));

    p_fetch_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_ins |-> !bk_we);

endmodule

// File: rtl/tcm_rd_return.sv
// Read return: remembers which bank served a granted read and presents
// that bank's data on the master's rdata one cycle later, zero otherwise.
// Assumes: the bank SRAM returns data one cycle after its enable.
module tcm_rd_return #(
    parameter int DATA_W = 32,
    parameter int NBANK  = 2,
    localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fire,
    input  logic [SEL_W-1:0]            bank,
    input  logic [NBANK-1:0][DATA_W-1:0] bk_rdata,
    output logic [DATA_W-1:0]           rdata
);

    logic             vld_q;
    logic [SEL_W-1:0] bank_q;

    // Capture the read grant and its bank for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            bank_q <= '0;
        end else begin
            vld_q  <= fire;
            bank_q <= bank;
        end
    end

    // Select the serving bank's data, or zero when no read is due.
    always_comb begin
        rdata = vld_q ? bk_rdata[bank_q] : '0;
    end

endmodule

// File: rtl/tcm_bank_arbiter.sv
// Top: decodes the fetch and load/store windows, splits every request by
// bank, runs one arbiter per bank and returns read data per master.
// Assumes: a master holds its request unchanged while ready is low; the
// bank SRAMs have one cycle of read latency and byte-write enables.
module tcm_bank_arbiter #(
    parameter int                    DATA_W   = 32,
    parameter int                    OFF_W    = 15,
    parameter int                    CPU_AW   = 17,
    parameter logic [CPU_AW-1:0]     INS_BASE = 17'h00000,
    parameter logic [CPU_AW-1:0]     DAT_BASE = 17'h10000,
    localparam int                   BE_W     = DATA_W / 8,
    localparam int                   LSB_W    = $clog2(BE_W),
    localparam int                   BANK_BIT = OFF_W - 1,
    localparam int                   IDX_W    = OFF_W - 1 - LSB_W,
    localparam int                   NBANK    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_req,
    input  logic [CPU_AW-1:0]           ins_addr,
    output logic                        ins_ready,
    output logic [DATA_W-1:0]           ins_rdata,
    input  logic                        dat_req,
    input  logic [CPU_AW-1:0]           dat_addr,
    input  logic                        dat_we,
    input  logic [BE_W-1:0]             dat_be,
    input  logic [DATA_W-1:0]           dat_wdata,
    output logic                        dat_ready,
    output logic [DATA_W-1:0]           dat_rdata,
    input  logic                        dma_req,
    input  logic [OFF_W-1:0]            dma_addr,
    input  logic                        dma_we,
    input  logic [BE_W-1:0]             dma_be,
    input  logic [DATA_W-1:0]           dma_wdata,
    output logic                        dma_ready,
    output logic [DATA_W-1:0]           dma_rdata,
    output logic [NBANK-1:0]            bk_en,
    output logic [NBANK-1:0]            bk_we,
    output logic [NBANK-1:0][BE_W-1:0]  bk_be,
    output logic [NBANK-1:0][IDX_W-1:0] bk_addr,
    output logic [NBANK-1:0][DATA_W-1:0] bk_wdata,
    input  logic [NBANK-1:0][DATA_W-1:0] bk_rdata
);

    logic             ins_win, dat_win;
    logic [OFF_W-1:0] ins_off, dat_off;
    logic             ins_bank, dat_bank, dma_bank;
    logic [IDX_W-1:0] ins_idx, dat_idx, dma_idx;
    logic [NBANK-1:0] gnt_ins, gnt_dat, gnt_dma;
    logic             ins_fire, dat_fire, dma_fire;

    tcm_win_decode #(.ADDR_W(CPU_AW), .OFF_W(OFF_W), .BASE(INS_BASE)) u_ins_win (
        .addr(ins_addr), .in_win(ins_win), .offset(ins_off)
    );

    tcm_win_decode #(.ADDR_W(CPU_AW), .OFF_W(OFF_W), .BASE(DAT_BASE)) u_dat_win (
        .addr(dat_addr), .in_win(dat_win), .offset(dat_off)
    );

    // Split each offset into bank select and bank word address.
    always_comb begin
        ins_bank = ins_off[BANK_BIT];
        dat_bank = dat_off[BANK_BIT];
        dma_bank = dma_addr[BANK_BIT];
        ins_idx  = ins_off[BANK_BIT-1:LSB_W];
        dat_idx  = dat_off[BANK_BIT-1:LSB_W];
        dma_idx  = dma_addr[BANK_BIT-1:LSB_W];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_ins, hit_dat, hit_dma;

        // Qualify each request for this bank.
        always_comb begin
            hit_ins = ins_req & ins_win & (ins_bank == 1'(b));
            hit_dat = dat_req & dat_win & (dat_bank == 1'(b));
            hit_dma = dma_req & (dma_bank == 1'(b));
        end

        tcm_bank_arb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_ins   (hit_ins),
            .idx_ins   (ins_idx),
            .hit_dat   (hit_dat),
            .idx_dat   (dat_idx),
            .we_dat    (dat_we),
            .be_dat    (dat_be),
            .wdata_dat (dat_wdata),
            .hit_dma   (hit_dma),
            .idx_dma   (dma_idx),
            .we_dma    (dma_we),
            .be_dma    (dma_be),
            .wdata_dma (dma_wdata),
            .gnt_ins   (gnt_ins[b]),
            .gnt_dat   (gnt_dat[b]),
            .gnt_dma   (gnt_dma[b]),
            .bk_en     (bk_en[b]),
            .bk_we     (bk_we[b]),
            .bk_be     (bk_be[b]),
            .bk_idx    (bk_addr[b]),
            .bk_wdata  (bk_wdata[b])
        );
    end

    // Ready: a bank grant, or an immediate answer for an out-of-window access.
    always_comb begin
        ins_ready = (ins_req & ~ins_win) | (|gnt_ins);
        dat_ready = (dat_req & ~dat_win) | (|gnt_dat);
        dma_ready = |gnt_dma;
        ins_fire  = |gnt_ins;
        dat_fire  = (|gnt_dat) & ~dat_we;
        dma_fire  = (|gnt_dma) & ~dma_we;
    end

    tcm_rd_return #(.DATA_W(DATA_W), .NBANK(NBANK)) u_ins_ret (
        .clk(clk), .rst_n(rst_n), .fire(ins_fire), .bank(ins_bank),
        .bk_rdata(bk_rdata), .rdata(ins_rdata)
    );

    tcm_rd_return #(.DATA_W(DATA_W), .NBANK(NBANK)) u_dat_ret (
        .clk(clk), .rst_n(rst_n), .fire(dat_fire), .bank(dat_bank),
        .bk_rdata(bk_rdata), .rdata(dat_rdata)
    );

    tcm_rd_return #(.DATA_W(DATA_W), .NBANK(NBANK)) u_dma_ret (
        .clk(clk), .rst_n(rst_n), .fire(dma_fire), .bank(dma_bank),
        .bk_rdata(bk_rdata), .rdata(dma_rdata)
    );

    p_oow_no_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_win && !dma_req && !(dat_req && dat_win)) |-> (bk_en == '0));

    p_oow_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_req && !dat_win) |-> (dat_ready && !(|gnt_dat)));

endmodule

// File: tb/tb_tcm_bank_arbiter.sv
// Bench: random traffic on all three ports, an SRAM model on the bank
// ports, and a behavioural reference that predicts ready and rdata.
module tb_tcm_bank_arbiter;

    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic        s_req [3];
    logic [16:0] s_addr [3];
    logic        s_win [3];
    logic [14:0] s_off [3];
    logic        s_we [3];
    logic [3:0]  s_be [3];
    logic [31:0] s_wd [3];

    logic              ins_ready, dat_ready, dma_ready;
    logic [31:0]       ins_rdata, dat_rdata, dma_rdata;
    logic [1:0]        bk_en, bk_we;
    logic [1:0][3:0]   bk_be;
    logic [1:0][11:0]  bk_addr;
    logic [1:0][31:0]  bk_wdata;
    logic [1:0][31:0]  bk_rdata;

    tcm_bank_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .ins_req(s_req[0]), .ins_addr(s_addr[0]),
        .ins_ready(ins_ready), .ins_rdata(ins_rdata),
        .dat_req(s_req[1]), .dat_addr(s_addr[1]), .dat_we(s_we[1]),
        .dat_be(s_be[1]), .dat_wdata(s_wd[1]),
        .dat_ready(dat_ready), .dat_rdata(dat_rdata),
        .dma_req(s_req[2]), .dma_addr(s_addr[2][14:0]), .dma_we(s_we[2]),
        .dma_be(s_be[2]), .dma_wdata(s_wd[2]),
        .dma_ready(dma_ready), .dma_rdata(dma_rdata),
        .bk_en(bk_en), .bk_we(bk_we), .bk_be(bk_be), .bk_addr(bk_addr),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    // SRAM model behind the bank ports, one cycle read latency.
    logic [31:0] sram [int];
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bk_en[b]) begin
                int k;
                logic [31:0] w;
                k = b * 4096 + int'(bk_addr[b]);
                w = sram.exists(k) ? sram[k] : 32'h0;
                if (bk_we[b]) begin
                    for (int y = 0; y < 4; y++)
                        if (bk_be[b][y]) w[8*y +: 8] = bk_wdata[b][8*y +: 8];
                    sram[k] = w;
                end else begin
                    bk_rdata[b] <= w;
                end
            end
        end
    end

    // Reference model state.
    logic [31:0] ref_mem [int];
    int          turn [2];
    logic        exp_ready [3];
    logic        exp_rv [3];
    logic [31:0] exp_rd [3];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    function automatic logic [31:0] act_rdata(int m);
        return (m == 0) ? ins_rdata : (m == 1) ? dat_rdata : dma_rdata;
    endfunction

    function automatic logic act_ready(int m);
        return (m == 0) ? ins_ready : (m == 1) ? dat_ready : dma_ready;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // New stimulus, except for a master still waiting (R7: hold request).
    task automatic gen_stim();
        for (int m = 0; m < 3; m++) begin
            if (!(s_req[m] && !exp_ready[m])) begin
                logic        oow;
                logic [14:0] off;
                s_req[m] = ($urandom % 4) != 0;
                off = 15'((($urandom % 2) << 14) | (($urandom % 8) << 2));
                if ($urandom % 8 == 0) off = 15'($urandom) & 15'h7ffc;
                oow = (m < 2) && ($urandom % 16 == 0);
                s_off[m] = off;
                s_win[m] = !oow;
                if (m == 0)      s_addr[m] = oow ? {2'b01, off} : {2'b00, off};
                else if (m == 1) s_addr[m] = oow ? {2'b11, off} : {2'b10, off};
                else             s_addr[m] = {2'b00, off};
                s_we[m] = (m == 0) ? 1'b0 : 1'($urandom % 2);
                s_be[m] = 4'($urandom);
                s_wd[m] = $urandom;
            end
        end
    endtask

    // One reference step: grants, ready compare, read prediction, writes.
    task automatic model_step();
        logic g [3];
        logic clash [2];
        logic cpu_on [2];
        string tag;
        for (int m = 0; m < 3; m++) g[m] = 1'b0;
        for (int b = 0; b < 2; b++) begin
            logic hi, hd, hm;
            hi = s_req[0] && s_win[0] && (s_off[0][14] == 1'(b));
            hd = s_req[1] && s_win[1] && (s_off[1][14] == 1'(b));
            hm = s_req[2] && (s_off[2][14] == 1'(b));
            clash[b] = hi && hd;
            cpu_on[b] = hi || hd;
            if (hi && hd) begin
                if (turn[b] == 0) g[0] = 1'b1; else g[1] = 1'b1;
                turn[b] = 1 - turn[b];
            end else if (hi) g[0] = 1'b1;
            else if (hd) g[1] = 1'b1;
            else if (hm) g[2] = 1'b1;
        end
        for (int m = 0; m < 3; m++) begin
            int bk;
            bk = int'(s_off[m][14]);
            exp_ready[m] = g[m] || (s_req[m] && !s_win[m]);
            if (s_req[m] && !s_win[m])          tag = "R3 ready";
            else if (m < 2 && clash[bk])        tag = "R6 R7 ready";
            else if (m == 2 && cpu_on[bk])      tag = "R5 R7 ready";
            else if (m == 0)                    tag = "R1 R4 ready";
            else                                tag = "R2 R4 ready";
            check($sformatf("%s port%0d", tag, m), 32'(act_ready(m)), 32'(exp_ready[m]));
            exp_rv[m] = g[m] && !s_we[m];
            if (exp_rv[m]) begin
                int k;
                k = int'(s_off[m][14:2]);
                exp_rd[m] = ref_mem.exists(k) ? ref_mem[k] : 32'h0;
            end
        end
        for (int m = 1; m < 3; m++) begin
            if (g[m] && s_we[m]) begin
                int k;
                logic [31:0] w;
                k = int'(s_off[m][14:2]);
                w = ref_mem.exists(k) ? ref_mem[k] : 32'h0;
                for (int y = 0; y < 4; y++)
                    if (s_be[m][y]) w[8*y +: 8] = s_wd[m][8*y +: 8];
                ref_mem[k] = w;
            end
        end
    endtask

    initial begin
        for (int m = 0; m < 3; m++) begin
            s_req[m] = 0; s_addr[m] = '0; s_win[m] = 1; s_off[m] = '0;
            s_we[m] = 0; s_be[m] = '0; s_wd[m] = '0;
            exp_ready[m] = 0; exp_rv[m] = 0; exp_rd[m] = '0;
        end
        turn[0] = 0; turn[1] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs after reset with no requests.
        for (int m = 0; m < 3; m++) begin
            check($sformatf("R10 rdata port%0d", m), act_rdata(m), 32'h0);
            check($sformatf("R10 ready port%0d", m), 32'(act_ready(m)), 32'h0);
        end
        check("R10 bank enable", 32'(bk_en), 32'h0);
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            for (int m = 0; m < 3; m++)
                check($sformatf("R2 R8 R9 rdata port%0d", m), act_rdata(m),
                      exp_rv[m] ? exp_rd[m] : 32'h0);
            gen_stim();
            #1;
            model_step();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule